// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address that a load or store uses. It takes a base register value and an offset, adds or subtracts the two, and sends the result out as the effective address, the base writeback value, or both, depending on the indexing mode. There are three indexing modes:

- **Plain offset**: the address is the sum and the base is left as it is.
- **Pre-indexed**: the address is the sum and the sum is also written back.
- **Post-indexed**: the address is the untouched base, and the sum is written back.

The offset can be one of three things: an immediate, an index register value, or an index register value shifted left by 0 to 3 bit positions.

A core pipeline presents one request per cycle with a valid strobe. The results come out of a register stage one clock later. Arithmetic is 32 bits wide and wraps silently.

Top module: `agu_top`

## Requirements
- R1: With `mode_in` = 2'b00 (plain offset), `addr_out` equals base plus or minus offset, and `wb_en_out` stays low.
- R2: With `mode_in` = 2'b01 (pre-indexed), `addr_out` and `wb_out` both equal base plus or minus offset, and `wb_en_out` is high.
- R3: With `mode_in` = 2'b10 (post-indexed), `addr_out` equals the unmodified base, `wb_out` equals base plus or minus offset, and `wb_en_out` is high.
- R4: `src_in` selects the offset source:
  - 2'b00 selects `imm_in`.
  - 2'b01 selects `index_in`.
  - 2'b10 selects `index_in` shifted left by `shamt_in`.
  - 2'b11 is treated as 2'b00.
- R5: `shamt_in` takes values 0 to 3. A shift of 0 passes `index_in` through unchanged. `shamt_in` has no effect unless `src_in` = 2'b10.
- R6: Addition and subtraction wrap modulo 2^32, and no fault is raised.
- R7: `sub_in` = 1 subtracts the offset from the base; `sub_in` = 0 adds it.
- R8: `valid_out` is high in exactly the cycle after a cycle with `valid_in` high. `wb_en_out` is never high unless `valid_out` is high.
- R9: A synchronous active-high `rst` clears `valid_out`, `wb_en_out`, `addr_out` and `wb_out` to zero.
- R10: The mode code 2'b11 behaves as plain offset mode, with no writeback.
- R11: In the cycle after a cycle with `valid_in` low, `addr_out` and `wb_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe |
| mode_in | input | 2 | Indexing mode code |
| src_in | input | 2 | Offset source select |
| shamt_in | input | 2 | Left shift for the shifted index form |
| sub_in | input | 1 | 1 = subtract the offset, 0 = add it |
| base_in | input | 32 | Base register value |
| imm_in | input | 32 | Immediate offset |
| index_in | input | 32 | Index register value |
| valid_out | output | 1 | Result strobe, one cycle after `valid_in` |
| addr_out | output | 32 | Effective address |
| wb_out | output | 32 | Base writeback value |
| wb_en_out | output | 1 | Base writeback request |

## Verification
In pre- and post-indexed modes the address and the writeback value both come from one adder result in the same registered cycle. Post-indexed mode is the case where the two must differ.

The bench drives requests that make base and sum differ by a visible amount, including sums that wrap past zero. It then checks both outputs and the strobe in the same sampled cycle against a model in the bench.

Requests are also issued back to back with alternating modes. Each idle cycle is checked to confirm that the previous pair of values holds while `valid_out` and `wb_en_out` fall.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        MODE_OFS  = 2'b00,
        MODE_PRE  = 2'b01,
        MODE_POST = 2'b10,
        MODE_ALT  = 2'b11
    } agu_mode_e;

    typedef enum logic [1:0] {
        SRC_IMM  = 2'b00,
        SRC_IDX  = 2'b01,
        SRC_SHL  = 2'b10,
        SRC_RSVD = 2'b11
    } agu_src_e;

endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen
    import agu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 2
) (
    input  agu_src_e            src,
    input  logic [SHAMT_W-1:0]  shamt,
    input  logic [DATA_W-1:0]   imm,
    input  logic [DATA_W-1:0]   index,
    output logic [DATA_W-1:0]   offset
);
    localparam int NSHIFT = 1 << SHAMT_W;

    logic [DATA_W-1:0] shifted [NSHIFT];

    for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
        assign shifted[s] = index << s;
    end

    always_comb begin
        unique case (src)
            SRC_IDX: offset = index;
            SRC_SHL: offset = shifted[shamt];
            default: offset = imm;
        endcase
    end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    input  logic              sub,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] operand;

    always_comb begin
        operand = sub ? ~offset : offset;
        sum     = base + operand + {{(DATA_W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/agu_mode_route.sv
module agu_mode_route
    import agu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  agu_mode_e          mode,
    input  logic [DATA_W-1:0]  base,
    input  logic [DATA_W-1:0]  sum,
    output logic [DATA_W-1:0]  addr,
    output logic [DATA_W-1:0]  wb,
    output logic               wb_req
);
    always_comb begin
        wb = sum;
        unique case (mode)
            MODE_PRE: begin
                addr   = sum;
                wb_req = 1'b1;
            end
            MODE_POST: begin
                addr   = base;
                wb_req = 1'b1;
            end
            default: begin
                addr   = sum;
                wb_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_in,
    input  logic [1:0]         mode_in,
    input  logic [1:0]         src_in,
    input  logic [SHAMT_W-1:0] shamt_in,
    input  logic               sub_in,
    input  logic [DATA_W-1:0]  base_in,
    input  logic [DATA_W-1:0]  imm_in,
    input  logic [DATA_W-1:0]  index_in,
    output logic               valid_out,
    output logic [DATA_W-1:0]  addr_out,
    output logic [DATA_W-1:0]  wb_out,
    output logic               wb_en_out
);
    typedef struct packed {
        logic              vld;
        logic              wb_en;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wb;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [DATA_W-1:0] offset_w, sum_w, addr_w, wb_w;
    logic              wb_req_w;

    agu_offset_gen #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_ofs (
        .src    (agu_src_e'(src_in)),
        .shamt  (shamt_in),
        .imm    (imm_in),
        .index  (index_in),
        .offset (offset_w)
    );

    agu_addsub #(.DATA_W(DATA_W)) u_add (
        .base   (base_in),
        .offset (offset_w),
        .sub    (sub_in),
        .sum    (sum_w)
    );

    agu_mode_route #(.DATA_W(DATA_W)) u_route (
        .mode   (agu_mode_e'(mode_in)),
        .base   (base_in),
        .sum    (sum_w),
        .addr   (addr_w),
        .wb     (wb_w),
        .wb_req (wb_req_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = valid_in;
        st_d.wb_en = valid_in & wb_req_w;
        if (valid_in) begin
            st_d.addr = addr_w;
            st_d.wb   = wb_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid_out = st_q.vld;
    assign wb_en_out = st_q.wb_en;
    assign addr_out  = st_q.addr;
    assign wb_out    = st_q.wb;

    // R8: strobe timing
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);
    p_wben_gated_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en_out |-> valid_out);
    // R1 / R10: no writeback in offset-type modes
    p_ofs_nowb_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (mode_in == 2'b00 || mode_in == 2'b11)) |=> !wb_en_out);
    // R2: pre-indexed address equals writeback value
    p_pre_same_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_in && mode_in == 2'b01) |=> (wb_en_out && addr_out == wb_out));
    // R3: post-indexed address is the base
    p_post_base_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && mode_in == 2'b10) |=> (wb_en_out && addr_out == $past(base_in)));
    // R11: outputs hold when idle
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(addr_out) && $stable(wb_out)));
endmodule

// File: tb/sim_agu_top.sv
module sim_agu_top;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic [1:0]  mode_in, src_in, shamt_in;
    logic        sub_in;
    logic [31:0] base_in, imm_in, index_in;
    logic        valid_out, wb_en_out;
    logic [31:0] addr_out, wb_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_top u0 (
        .clk(clk), .rst(rst), .valid_in(valid_in), .mode_in(mode_in),
        .src_in(src_in), .shamt_in(shamt_in), .sub_in(sub_in),
        .base_in(base_in), .imm_in(imm_in), .index_in(index_in),
        .valid_out(valid_out), .addr_out(addr_out), .wb_out(wb_out),
        .wb_en_out(wb_en_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_off(input logic [1:0] src, input logic [1:0] sh,
                                              input logic [31:0] imm, input logic [31:0] idx);
        case (src)
            2'b01:   return idx;
            2'b10:   return idx << sh;
            default: return imm;
        endcase
    endfunction

    // issue one request, check registered results one clock later
    task automatic run_req(input string req, input logic [1:0] md, input logic [1:0] src,
                           input logic [1:0] sh, input logic sb, input logic [31:0] base,
                           input logic [31:0] imm, input logic [31:0] idx);
        logic [31:0] off, sum, exp_addr;
        logic        exp_wb;
        off      = model_off(src, sh, imm, idx);
        sum      = sb ? base - off : base + off;
        exp_addr = (md == 2'b10) ? base : sum;
        exp_wb   = (md == 2'b01 || md == 2'b10);
        @(negedge clk);
        valid_in = 1'b1; mode_in = md; src_in = src; shamt_in = sh; sub_in = sb;
        base_in = base; imm_in = imm; index_in = idx;
        @(posedge clk); #1;
        chk(req, "valid_out", {31'd0, valid_out}, 32'd1);
        chk(req, "addr_out", addr_out, exp_addr);
        chk(req, "wb_out", wb_out, sum);
        chk(req, "wb_en_out", {31'd0, wb_en_out}, {31'd0, exp_wb});
    endtask

    task automatic idle_chk(input string req);
        logic [31:0] a, w;
        a = addr_out; w = wb_out;
        @(negedge clk);
        valid_in = 1'b0; base_in = 32'hDEAD_BEEF; imm_in = 32'h1234; index_in = 32'h77;
        @(posedge clk); #1;
        chk(req, "valid_out idle", {31'd0, valid_out}, 32'd0);
        chk(req, "wb_en_out idle", {31'd0, wb_en_out}, 32'd0);
        chk(req, "addr hold", addr_out, a);
        chk(req, "wb hold", wb_out, w);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b1; mode_in = 2'b01;
        @(posedge clk); #1;
        chk("R9", "valid_out", {31'd0, valid_out}, 32'd0);
        chk("R9", "wb_en_out", {31'd0, wb_en_out}, 32'd0);
        chk("R9", "addr_out", addr_out, 32'd0);
        chk("R9", "wb_out", wb_out, 32'd0);
        @(negedge clk);
        rst = 1'b0; valid_in = 1'b0;
    endtask

    task automatic t_modes();
        run_req("R1", 2'b00, 2'b00, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_0024, 32'h0);
        run_req("R2", 2'b01, 2'b01, 2'd0, 1'b0, 32'h2000_0000, 32'h0, 32'h0000_0100);
        run_req("R3", 2'b10, 2'b00, 2'd0, 1'b0, 32'h2000_0800, 32'h0000_0004, 32'h0);
        run_req("R10", 2'b11, 2'b00, 2'd0, 1'b0, 32'h0000_4000, 32'h0000_0010, 32'h0);
    endtask

    task automatic t_sources();
        run_req("R4", 2'b01, 2'b10, 2'd3, 1'b0, 32'h0000_1000, 32'h0, 32'h0000_0011);
        run_req("R4", 2'b00, 2'b11, 2'd2, 1'b0, 32'h0000_1000, 32'h0000_0030, 32'h0000_0500);
        run_req("R5", 2'b00, 2'b10, 2'd0, 1'b0, 32'h0000_0100, 32'h0, 32'h0000_0007);
        run_req("R5", 2'b00, 2'b01, 2'd3, 1'b0, 32'h0000_0100, 32'h0, 32'h0000_0007);
        run_req("R5", 2'b10, 2'b00, 2'd3, 1'b0, 32'h0000_0100, 32'h0000_0009, 32'h0000_0007);
    endtask

    task automatic t_arith();
        run_req("R7", 2'b01, 2'b01, 2'd0, 1'b1, 32'h0000_1000, 32'h0, 32'h0000_0010);
        run_req("R7", 2'b10, 2'b10, 2'd2, 1'b1, 32'h0000_1000, 32'h0, 32'h0000_0004);
        run_req("R6", 2'b01, 2'b00, 2'd0, 1'b0, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0);
        run_req("R6", 2'b10, 2'b00, 2'd0, 1'b1, 32'h0000_0004, 32'h0000_0010, 32'h0);
        run_req("R6", 2'b00, 2'b10, 2'd3, 1'b0, 32'h8000_0000, 32'h0, 32'h1000_0000);
    endtask

    task automatic t_timing();
        idle_chk("R11");
        run_req("R8", 2'b10, 2'b01, 2'd0, 1'b0, 32'h0000_0200, 32'h0, 32'h0000_0008);
        run_req("R8", 2'b00, 2'b01, 2'd0, 1'b0, 32'h0000_0300, 32'h0, 32'h0000_0008);
        idle_chk("R8");
        idle_chk("R11");
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_in = 1'b0; mode_in = '0; src_in = '0; shamt_in = '0;
        sub_in = 1'b0; base_in = '0; imm_in = '0; index_in = '0;
        repeat (2) @(posedge clk);
        t_reset();
        t_modes();
        t_sources();
        t_arith();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule